// File: doc/BRIEF.md
# Converter Test Pattern Generator

This block sits on the 16-bit sample path of a data converter. It either forwards live converter words or replaces them with a generated test word. A 4-bit pattern code selects the source. The choices are fixed levels, alternating and walking patterns, two pseudo-random bit streams, and one or two user-supplied words. The words can repeat forever or go out only once. Downstream logic can then check the link against a known sequence without an analog input.

The output register advances only on a sample strobe, so one word is produced per converter sample. Writing a new configuration is marked by a one-cycle `mode_wr` pulse. That pulse restarts the sample index, which drives the alternating, walking and mixed patterns and the user-word sequencing. The two pseudo-random generators have their own reseed controls. These controls act whatever the pattern code is.

Top module: `adc_test_pattern`

## Requirements
- R1: Pattern code 0000 and the unused codes 1101, 1110 and 1111 pass `live_data` to `data_out` one clock after a cycle with `sample_en` high. With `sample_en` low, `data_out` holds its value.
- R2: Code 0001 gives 0x8000, code 0010 gives 0xFFFF and code 0011 gives 0x0000.
- R3: A `mode_wr` pulse sets the sample index to 0, and every sample adds one to it. Code 0100 gives 0xAAAA at even index and 0x5555 at odd index. Code 0111 gives 0xFFFF at even index and 0x0000 at odd index.
- R4: Code 0110 gives the short stream. It is a 9-bit shift register with feedback s[8]^s[4] (x^9+x^5+1). Each step shifts the register left and inserts the new bit at s[0]. Each sample takes 16 steps, and the first new bit lands in bit 15 of the word.
- R5: Code 0101 gives the long stream. It is built the same way as R4, with a 23-bit register and feedback s[22]^s[17] (x^23+x^18+1).
- R6: Each generator starts from all ones after reset. It is reloaded to all ones by its own clear input (`prbs_short_clr` for the short stream, `prbs_long_clr` for the long stream). A clear takes priority over a step. A generator advances only on samples taken while its own code is selected.
- R7: Code 1000 with `usr_seq` 00 outputs `usr_word_a` on every sample. With `usr_seq` 01 it outputs `usr_word_a` at even index and `usr_word_b` at odd index.
- R8: With `usr_seq` 10, code 1000 outputs `usr_word_a` once. With `usr_seq` 11 it outputs `usr_word_a` and then `usr_word_b`. In both cases the output is then 0x0000 on every sample until the next `mode_wr`.
- R9: Code 1001 gives 0x5555 and code 1010 gives the sync word 0x00FF on every sample.
- R10: Code 1011 gives a single high bit at position (index mod 16).
- R11: Code 1100 gives the low 4 bits of the index repeated four times, so bit n toggles at a rate set by n mod 4.
- R12: After reset, `data_out` is 0x0000 and the sample index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | One-cycle pulse when the configuration is written |
| pat_mode | input | 4 | Pattern code |
| usr_seq | input | 2 | User-word sequencing: 00 single, 01 alternate, 10 single once, 11 alternate once |
| usr_word_a | input | 16 | First user word |
| usr_word_b | input | 16 | Second user word |
| prbs_long_clr | input | 1 | Reload the 23-bit generator to all ones |
| prbs_short_clr | input | 1 | Reload the 9-bit generator to all ones |
| sample_en | input | 1 | One output word per cycle when high |
| live_data | input | 16 | Converter sample |
| data_out | output | 16 | Selected output word |

## Verification
Every fixed code is tried against changing live words. This shows a real replacement apart from a pass-through that only happens to match. Each indexed pattern is followed over several samples after a fresh `mode_wr`. This exposes wrong phase, wrong rate, and an index that does not restart. Both streams are compared word by word with a model of their polynomials. One stream is reseeded while the other runs, which shows the two clears are separate. The four user sequencings are each run past their last word and then rewritten, which checks both the zero hold and the restart.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TPG_DATA_W = 16;

    typedef enum logic [3:0] {
        PAT_OFF    = 4'b0000,
        PAT_MID    = 4'b0001,
        PAT_POSFS  = 4'b0010,
        PAT_NEGFS  = 4'b0011,
        PAT_CHECK  = 4'b0100,
        PAT_PRBS23 = 4'b0101,
        PAT_PRBS9  = 4'b0110,
        PAT_WTOG   = 4'b0111,
        PAT_USER   = 4'b1000,
        PAT_BTOG   = 4'b1001,
        PAT_SYNC   = 4'b1010,
        PAT_WALK   = 4'b1011,
        PAT_MIX    = 4'b1100
    } pat_e;

    typedef enum logic [1:0] {
        USR_SINGLE      = 2'b00,
        USR_ALT         = 2'b01,
        USR_SINGLE_ONCE = 2'b10,
        USR_ALT_ONCE    = 2'b11
    } usr_seq_e;

    // user sequencing decoded into the two properties that matter
    typedef struct packed {
        logic alt;
        logic once;
    } usr_ctl_t;

    function automatic usr_ctl_t decode_usr(input logic [1:0] code);
        usr_ctl_t c;
        c.alt  = (code == USR_ALT) || (code == USR_ALT_ONCE);
        c.once = (code == USR_SINGLE_ONCE) || (code == USR_ALT_ONCE);
        return c;
    endfunction

    function automatic logic is_pat(input logic [3:0] code, input pat_e p);
        return code == 4'(p);
    endfunction

endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
    parameter int ORDER = 9,
    parameter int TAP   = 5,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reseed,
    input  logic         step,
    output logic [W-1:0] word
);

    localparam logic [ORDER-1:0] SEED = '1;

    logic [ORDER-1:0] state_q;
    logic [ORDER-1:0] state_nxt;

    // W serial steps unrolled; first new bit lands in the MSB
    always_comb begin
        logic [ORDER-1:0] s;
        logic             nb;
        s    = state_q;
        word = '0;
        for (int i = 0; i < W; i++) begin
            nb          = s[ORDER-1] ^ s[TAP-1];
            s           = {s[ORDER-2:0], nb};
            word[W-1-i] = nb;
        end
        state_nxt = s;
    end

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    AST_PRBS_RESEED: assert property (@(posedge clk) disable iff (rst)
        reseed |=> state_q == SEED); // R6
    AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reseed && !step) |=> $stable(state_q)); // R6
    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q != '0); // R4

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic             user_sel,
    input  logic             once,
    input  logic             alt,
    output logic [CNT_W-1:0] idx,
    output logic             spent
);

    logic [CNT_W-1:0] last_idx;
    logic             last_word;

    assign last_idx  = alt ? CNT_W'(1) : CNT_W'(0);
    assign last_word = advance && user_sel && once && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx   <= '0;
            spent <= 1'b0;
        end else if (advance) begin
            idx <= idx + CNT_W'(1);
            if (last_word) begin
                spent <= 1'b1;
            end
        end
    end

    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (idx == '0 && !spent)); // R3
    AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (spent && !restart) |=> spent); // R8
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !restart) |=> idx == $past(idx) + CNT_W'(1)); // R3

endmodule

// File: rtl/tpg_mux.sv
module tpg_mux #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic [3:0]        pat_code,
    input  tpg_pkg::usr_ctl_t usr,
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] prbs_long,
    input  logic [DATA_W-1:0] prbs_short,
    input  logic [CNT_W-1:0]  idx,
    input  logic              spent,
    output logic [DATA_W-1:0] word
);
    import tpg_pkg::*;

    localparam int HALF = DATA_W / 2;
    localparam int REPS = DATA_W / CNT_W;
    localparam logic [DATA_W-1:0] MID_LVL = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ALT_HI  = {HALF{2'b10}};
    localparam logic [DATA_W-1:0] ALT_LO  = {HALF{2'b01}};
    localparam logic [DATA_W-1:0] SYNC_W  = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic [DATA_W-1:0] user_w;
    logic [DATA_W-1:0] walk_w;
    logic [DATA_W-1:0] mix_w;

    assign user_w = spent ? '0 : ((usr.alt && idx[0]) ? word_b : word_a);
    assign walk_w = DATA_W'(1) << idx;

    for (genvar r = 0; r < REPS; r++) begin : g_mix
        assign mix_w[r*CNT_W +: CNT_W] = idx;
    end

    always_comb begin
        unique case (pat_code)
            PAT_MID:    word = MID_LVL;
            PAT_POSFS:  word = '1;
            PAT_NEGFS:  word = '0;
            PAT_CHECK:  word = idx[0] ? ALT_LO : ALT_HI;
            PAT_PRBS23: word = prbs_long;
            PAT_PRBS9:  word = prbs_short;
            PAT_WTOG:   word = idx[0] ? '0 : '1;
            PAT_USER:   word = user_w;
            PAT_BTOG:   word = ALT_LO;
            PAT_SYNC:   word = SYNC_W;
            PAT_WALK:   word = walk_w;
            PAT_MIX:    word = mix_w;
            default:    word = live;
        endcase
    end

endmodule

// File: rtl/adc_test_pattern.sv
module adc_test_pattern #(
    parameter int DATA_W     = tpg_pkg::TPG_DATA_W,
    parameter int LONG_ORD   = 23,
    parameter int LONG_TAP   = 18,
    parameter int SHORT_ORD  = 9,
    parameter int SHORT_TAP  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [3:0]        pat_mode,
    input  logic [1:0]        usr_seq,
    input  logic [DATA_W-1:0] usr_word_a,
    input  logic [DATA_W-1:0] usr_word_b,
    input  logic              prbs_long_clr,
    input  logic              prbs_short_clr,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] live_data,
    output logic [DATA_W-1:0] data_out
);
    import tpg_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    usr_ctl_t          usr;
    logic              user_sel;
    logic [CNT_W-1:0]  idx;
    logic              spent;
    logic [DATA_W-1:0] long_w;
    logic [DATA_W-1:0] short_w;
    logic [DATA_W-1:0] word_nxt;

    assign usr      = decode_usr(usr_seq);
    assign user_sel = is_pat(pat_mode, PAT_USER);

    tpg_prbs #(.ORDER(LONG_ORD), .TAP(LONG_TAP), .W(DATA_W)) i_prbs_long (
        .clk    (clk),
        .rst    (rst),
        .reseed (prbs_long_clr),
        .step   (sample_en && is_pat(pat_mode, PAT_PRBS23)),
        .word   (long_w)
    );

    tpg_prbs #(.ORDER(SHORT_ORD), .TAP(SHORT_TAP), .W(DATA_W)) i_prbs_short (
        .clk    (clk),
        .rst    (rst),
        .reseed (prbs_short_clr),
        .step   (sample_en && is_pat(pat_mode, PAT_PRBS9)),
        .word   (short_w)
    );

    tpg_seq #(.CNT_W(CNT_W)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (mode_wr),
        .advance  (sample_en),
        .user_sel (user_sel),
        .once     (usr.once),
        .alt      (usr.alt),
        .idx      (idx),
        .spent    (spent)
    );

    tpg_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_mux (
        .pat_code   (pat_mode),
        .usr        (usr),
        .word_a     (usr_word_a),
        .word_b     (usr_word_b),
        .live       (live_data),
        .prbs_long  (long_w),
        .prbs_short (short_w),
        .idx        (idx),
        .spent      (spent),
        .word       (word_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out <= '0;
        end else if (sample_en) begin
            data_out <= word_nxt;
        end
    end

    AST_LIVE_PASS: assert property (@(posedge clk) disable iff (rst)
        (sample_en && pat_mode == 4'(PAT_OFF)) |=> data_out == $past(live_data)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(data_out)); // R1
    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (sample_en && pat_mode == 4'(PAT_POSFS)) |=> data_out == '1); // R2
    AST_ONCE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sample_en && user_sel && spent) |=> data_out == '0); // R8
    AST_WALK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (sample_en && pat_mode == 4'(PAT_WALK)) |=> $countones(data_out) == 1); // R10

endmodule

// File: tb/test_adc_test_pattern.sv
`timescale 1ns/1ps
module test_adc_test_pattern;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [3:0]  pat_mode = 4'd0;
    logic [1:0]  usr_seq = 2'd0;
    logic [15:0] usr_word_a = 16'h1357;
    logic [15:0] usr_word_b = 16'h9ACE;
    logic        prbs_long_clr = 1'b0;
    logic        prbs_short_clr = 1'b0;
    logic        sample_en = 1'b0;
    logic [15:0] live_data = 16'h0;
    logic [15:0] data_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_test_pattern i_adc_test_pattern (
        .clk            (clk),
        .rst            (rst),
        .mode_wr        (mode_wr),
        .pat_mode       (pat_mode),
        .usr_seq        (usr_seq),
        .usr_word_a     (usr_word_a),
        .usr_word_b     (usr_word_b),
        .prbs_long_clr  (prbs_long_clr),
        .prbs_short_clr (prbs_short_clr),
        .sample_en      (sample_en),
        .live_data      (live_data),
        .data_out       (data_out)
    );

    // {code, live word, expected word}
    localparam logic [35:0] VEC [8] = '{
        {4'b0000, 16'h1234, 16'h1234},   // R1
        {4'b0001, 16'h1111, 16'h8000},   // R2
        {4'b0010, 16'h2222, 16'hFFFF},   // R2
        {4'b0011, 16'h3333, 16'h0000},   // R2
        {4'b1001, 16'h4444, 16'h5555},   // R9
        {4'b1010, 16'h5555, 16'h00FF},   // R9
        {4'b1101, 16'hBEEF, 16'hBEEF},   // R1
        {4'b1111, 16'h0F0F, 16'h0F0F}    // R1
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m, input logic [1:0] s);
        @(negedge clk);
        pat_mode = m;
        usr_seq  = s;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    // serial model of the streams in R4/R5
    function automatic logic [15:0] prbs_word(inout logic [31:0] st, input int order, input int tap);
        logic [15:0] w;
        logic        nb;
        w = '0;
        for (int i = 0; i < 16; i++) begin
            nb = st[order-1] ^ st[tap-1];
            st = ((st << 1) | 32'(nb)) & ((32'd1 << order) - 1);
            w  = {w[14:0], nb};
        end
        return w;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] s9;
        logic [31:0] s23;
        logic [15:0] held;
        s9  = 32'h1FF;
        s23 = 32'h7FFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", data_out, 16'h0000);

        // table walk over fixed codes
        for (int v = 0; v < 8; v++) begin
            set_mode(VEC[v][35:32], 2'b00);
            live_data = VEC[v][31:16];
            step();
            check("R1/R2/R9 table", data_out, VEC[v][15:0]);
            live_data = ~VEC[v][31:16];
            step();
            check("R1/R2/R9 table repeat", data_out,
                  (VEC[v][35:32] == 4'b0000 || VEC[v][35:32] >= 4'b1101) ? ~VEC[v][31:16] : VEC[v][15:0]);
        end

        // hold without sample strobe
        set_mode(4'b0000, 2'b00);
        live_data = 16'hC0DE;
        step();
        held = data_out;
        live_data = 16'h7777;
        repeat (4) @(negedge clk);
        check("R1 hold", data_out, held);

        // checkerboard and word toggle
        set_mode(4'b0100, 2'b00);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3 checker", data_out, (k % 2 == 0) ? 16'hAAAA : 16'h5555);
        end
        set_mode(4'b0111, 2'b00);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3 word toggle", data_out, (k % 2 == 0) ? 16'hFFFF : 16'h0000);
        end

        // short stream from seed
        set_mode(4'b0110, 2'b00);
        for (int k = 0; k < 4; k++) begin
            step();
            check("R4 short stream", data_out, prbs_word(s9, 9, 5));
        end
        // long stream from seed, untouched by short-stream use
        set_mode(4'b0101, 2'b00);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R5 long stream", data_out, prbs_word(s23, 23, 18));
        end
        // clearing the short generator leaves the long one running
        @(negedge clk);
        prbs_short_clr = 1'b1;
        @(negedge clk);
        prbs_short_clr = 1'b0;
        step();
        check("R6 long unaffected", data_out, prbs_word(s23, 23, 18));
        // long clear reseeds it
        @(negedge clk);
        prbs_long_clr = 1'b1;
        @(negedge clk);
        prbs_long_clr = 1'b0;
        s23 = 32'h7FFFFF;
        step();
        check("R6 long reseed", data_out, prbs_word(s23, 23, 18));
        // short generator restarts at seed after its clear
        s9 = 32'h1FF;
        set_mode(4'b0110, 2'b00);
        step();
        check("R6 short reseed", data_out, prbs_word(s9, 9, 5));

        // user words
        set_mode(4'b1000, 2'b00);
        step(); check("R7 single", data_out, 16'h1357);
        step(); check("R7 single", data_out, 16'h1357);
        set_mode(4'b1000, 2'b01);
        step(); check("R7 alternate", data_out, 16'h1357);
        step(); check("R7 alternate", data_out, 16'h9ACE);
        step(); check("R7 alternate", data_out, 16'h1357);
        set_mode(4'b1000, 2'b10);
        step(); check("R8 single once", data_out, 16'h1357);
        step(); check("R8 single once", data_out, 16'h0000);
        step(); check("R8 single once", data_out, 16'h0000);
        set_mode(4'b1000, 2'b11);
        step(); check("R8 alt once", data_out, 16'h1357);
        step(); check("R8 alt once", data_out, 16'h9ACE);
        for (int k = 0; k < 3; k++) begin
            step(); check("R8 alt once hold", data_out, 16'h0000);
        end
        set_mode(4'b1000, 2'b11);
        step(); check("R8 rewrite restarts", data_out, 16'h1357);

        // walking one over a wrap
        set_mode(4'b1011, 2'b00);
        for (int k = 0; k < 18; k++) begin
            step();
            check("R10 walking one", data_out, 16'(1) << (k % 16));
        end

        // mixed frequency
        set_mode(4'b1100, 2'b00);
        for (int k = 0; k < 6; k++) begin
            logic [3:0] n;
            n = 4'(k);
            step();
            check("R11 mixed", data_out, {n, n, n, n});
        end

        // reset mid-run restores zero output and index
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 reset output", data_out, 16'h0000);
        pat_mode = 4'b0100;
        step();
        check("R12 reset index", data_out, 16'hAAAA);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule